// File: doc/BRIEF.md
# Reconfigurable Custom-Instruction Execution Unit

This unit sits next to the execute stage of a 32-bit single-issue pipeline and computes custom instructions. It holds a single row of eight 32-bit processing elements. Each element can act as an adder, a logic unit, a shifter or a multiplier. Every custom instruction reads up to four register operands and returns one 32-bit value. The operand limit matches the register-file read ports given to the unit.

How the row is wired for an instruction is stored in one of sixteen configuration contexts, each 134 bits wide. The issuing instruction word carries the 4-bit context index. A different context may be used on every cycle, so one custom instruction can issue per cycle with no reconfiguration stall. Inside a context, each element chooses its two inputs from the external operands, from the outputs of elements to its left, or from a small per-element constant. An output-select field names the element whose value becomes the result.

The datapath from operands to result is combinational. The result is registered, so it appears with a valid flag one cycle after issue. A two-state result machine drives the valid flag. Its states are EMPTY (no fresh result) and FULL (a fresh result). The ISSUE transition moves from either state to FULL when an instruction issues. The IDLE transition moves from FULL to EMPTY on a cycle with no issue. A separate write port replaces one whole context per cycle.

Top module: `rfu_unit`

## Requirements
- R1: After reset, res_valid is 0, res_data is 0, and every context is all zeros, so issuing any context returns operand 0 (issue_opnds[31:0]).
- R2: If issue_valid is high in a cycle, then after that clock edge res_valid is 1 and res_data holds the result of that cycle's operands and context. If issue_valid is low, res_valid is 0 after the edge and res_data keeps its previous value.
- R3: Element p is configured by context bits [16p+15:16p]: opcode [3:0], source A [7:4], source B [11:8], constant [15:12]. The opcodes are: 0 pass A, 1 A+B, 2 A-B, 3 AND, 4 OR, 5 XOR, 6 A shifted left by B[4:0], 7 logical right shift, 8 arithmetic right shift, 9 low 32 bits of A*B, 10 signed A<B (1 or 0), 11 unsigned A<B. Opcodes 12 to 15 give 0.
- R4: For element p, source code s selects operand s when s<4. It selects the output of element s-4 when 4<=s<4+p. Any larger code selects the element's 4-bit constant, zero-extended. This includes codes that point at the element itself or at elements to its right.
- R5: Context bits [130:128] name the element (0 to 7) whose output becomes the result.
- R6: Context bits [133:131] are reserved and have no effect on the result.
- R7: The context is picked by issue_ctx each cycle. Back-to-back issues may use different contexts and each gets its own result.
- R8: With cfg_we high, cfg_word is stored in context cfg_idx at the clock edge. An instruction that issues in that same cycle uses the previous contents. The new contents apply from the next cycle.
- R9: All eight elements may be chained in one context, and the chain completes within the single issue cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | A custom instruction issues this cycle |
| issue_ctx | input | 4 | Context index from the instruction word |
| issue_opnds | input | 128 | Four 32-bit operands, operand k at bits [32k+31:32k] |
| cfg_we | input | 1 | Context write enable |
| cfg_idx | input | 4 | Context to write |
| cfg_word | input | 134 | Full context contents |
| res_valid | output | 1 | Result valid, one cycle after issue |
| res_data | output | 32 | Registered result |

## Verification
A context write and an issue can fall in the same cycle and target the same context. The bench provokes this by raising cfg_we for context 5 at the same time as it issues context 5. The old context performs addition and the new one performs multiplication. The first result must be the sum. A second issue of context 5 on the very next cycle must return the product. Back-to-back issues that alternate between contexts also show that the context change takes effect in every cycle.

// File: rtl/rfu_pkg.sv
package rfu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_PASS = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_SLL  = 4'd6,
        OP_SRL  = 4'd7,
        OP_SRA  = 4'd8,
        OP_MUL  = 4'd9,
        OP_SLT  = 4'd10,
        OP_SLTU = 4'd11
    } pe_op_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } res_state_e;

endpackage

// File: rtl/rfu_ctx_mem.sv
module rfu_ctx_mem #(
    parameter int CTX_W   = 134,
    parameter int NUM_CTX = 16,
    localparam int IDX_W  = $clog2(NUM_CTX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [CTX_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CTX_W-1:0] rd_data
);

    logic [CTX_W-1:0] slots_q [NUM_CTX];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CTX; i++) slots_q[i] <= '0;
        end else if (wr_en) begin
            slots_q[wr_idx] <= wr_data;
        end
    end

    // Read sees the contents before any write in the same cycle
    always_comb rd_data = slots_q[rd_idx];

    // R8
    wr_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (slots_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/rfu_pe.sv
module rfu_pe
    import rfu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_IN = 4,
    parameter int NUM_PE = 8,
    parameter int IDX    = 0,
    parameter int SEL_W  = 4,
    parameter int IMM_W  = 4
) (
    input  logic [NUM_IN*DATA_W-1:0] opnds,
    input  logic [NUM_PE*DATA_W-1:0] peers,
    input  logic [OP_W-1:0]          op,
    input  logic [SEL_W-1:0]         sel_a,
    input  logic [SEL_W-1:0]         sel_b,
    input  logic [IMM_W-1:0]         imm,
    output logic [DATA_W-1:0]        y
);

    localparam int SH_W = $clog2(DATA_W);

    logic [DATA_W-1:0] a;
    logic [DATA_W-1:0] b;
    logic              unused_peers;

    // Only elements to the left are reachable; the rest of the bus is ignored
    assign unused_peers = ^peers;

    function automatic logic [DATA_W-1:0] pick(input logic [SEL_W-1:0] code);
        int c;
        c = int'(code);
        if (c < NUM_IN)
            return opnds[c*DATA_W +: DATA_W];
        else if (c < NUM_IN + IDX)
            return peers[(c-NUM_IN)*DATA_W +: DATA_W];
        else
            return DATA_W'(imm);
    endfunction

    always_comb begin
        a = pick(sel_a);
        b = pick(sel_b);
    end

    always_comb begin
        case (op)
            OP_PASS: y = a;
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SLL:  y = a << b[SH_W-1:0];
            OP_SRL:  y = a >> b[SH_W-1:0];
            OP_SRA:  y = DATA_W'($signed(a) >>> b[SH_W-1:0]);
            OP_MUL:  y = a * b;
            OP_SLT:  y = {{(DATA_W-1){1'b0}}, ($signed(a) < $signed(b))};
            OP_SLTU: y = {{(DATA_W-1){1'b0}}, (a < b)};
            default: y = '0;
        endcase
    end

    always_comb begin
        // R3
        if (op == OP_ADD && b == '0) add_ident_chk: assert (y == a);
        // R3
        if (op == OP_XOR && a == b) xor_self_chk: assert (y == '0);
        // R3
        if (op == OP_SLT || op == OP_SLTU) cmp_bit_chk: assert (y[DATA_W-1:1] == '0);
    end

endmodule

// File: rtl/rfu_array.sv
module rfu_array
    import rfu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_IN = 4,
    parameter int NUM_PE = 8,
    parameter int IMM_W  = 4,
    parameter int CTX_W  = 134,
    localparam int SEL_W  = $clog2(NUM_IN + NUM_PE + 1),
    localparam int PE_W   = OP_W + 2*SEL_W + IMM_W,
    localparam int OSEL_W = $clog2(NUM_PE),
    localparam int USED_W = NUM_PE*PE_W + OSEL_W
) (
    input  logic [NUM_IN*DATA_W-1:0] opnds,
    input  logic [CTX_W-1:0]         ctx,
    output logic [DATA_W-1:0]        result
);

    logic [NUM_PE*DATA_W-1:0] pe_y;
    logic [OSEL_W-1:0]        out_sel;

    generate
        for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
            logic [PE_W-1:0] fld;
            assign fld = ctx[p*PE_W +: PE_W];

            rfu_pe #(
                .DATA_W(DATA_W),
                .NUM_IN(NUM_IN),
                .NUM_PE(NUM_PE),
                .IDX   (p),
                .SEL_W (SEL_W),
                .IMM_W (IMM_W)
            ) u_pe (
                .opnds(opnds),
                .peers(pe_y),
                .op   (fld[OP_W-1:0]),
                .sel_a(fld[OP_W +: SEL_W]),
                .sel_b(fld[OP_W+SEL_W +: SEL_W]),
                .imm  (fld[OP_W+2*SEL_W +: IMM_W]),
                .y    (pe_y[p*DATA_W +: DATA_W])
            );
        end

        if (CTX_W > USED_W) begin : g_rsvd
            logic unused_rsvd;
            assign unused_rsvd = ^ctx[CTX_W-1:USED_W];
        end
    endgenerate

    assign out_sel = ctx[NUM_PE*PE_W +: OSEL_W];

    always_comb result = pe_y[int'(out_sel)*DATA_W +: DATA_W];

endmodule

// File: rtl/rfu_unit.sv
module rfu_unit
    import rfu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_IN  = 4,
    parameter int NUM_PE  = 8,
    parameter int NUM_CTX = 16,
    parameter int IMM_W   = 4,
    parameter int CTX_W   = 134,
    localparam int IDX_W  = $clog2(NUM_CTX),
    localparam int OPND_W = NUM_IN*DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic [IDX_W-1:0]  issue_ctx,
    input  logic [OPND_W-1:0] issue_opnds,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [CTX_W-1:0]  cfg_word,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data
);

    res_state_e        st_q, st_d;
    logic [CTX_W-1:0]  cur_ctx;
    logic [DATA_W-1:0] arr_result;
    logic [DATA_W-1:0] res_q;

    rfu_ctx_mem #(
        .CTX_W  (CTX_W),
        .NUM_CTX(NUM_CTX)
    ) u_ctx (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_idx (cfg_idx),
        .wr_data(cfg_word),
        .rd_idx (issue_ctx),
        .rd_data(cur_ctx)
    );

    rfu_array #(
        .DATA_W(DATA_W),
        .NUM_IN(NUM_IN),
        .NUM_PE(NUM_PE),
        .IMM_W (IMM_W),
        .CTX_W (CTX_W)
    ) u_arr (
        .opnds (issue_opnds),
        .ctx   (cur_ctx),
        .result(arr_result)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: if (issue_valid)  st_d = ST_FULL;
            ST_FULL:  if (!issue_valid) st_d = ST_EMPTY;
            default:  st_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    // Result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           res_q <= '0;
        else if (issue_valid) res_q <= arr_result;
    end

    // Outputs
    always_comb begin
        res_valid = (st_q == ST_FULL);
        res_data  = res_q;
    end

    // R2
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> res_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> !res_valid);

    // R2
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |=> $stable(res_data));

endmodule

// File: tb/tb_rfu_unit.sv
`timescale 1ns/1ps
module tb_rfu_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue_valid = 1'b0;
    logic [3:0]   issue_ctx = '0;
    logic [127:0] issue_opnds = '0;
    logic         cfg_we = 1'b0;
    logic [3:0]   cfg_idx = '0;
    logic [133:0] cfg_word = '0;
    logic         res_valid;
    logic [31:0]  res_data;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    rfu_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_valid(issue_valid),
        .issue_ctx  (issue_ctx),
        .issue_opnds(issue_opnds),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_word   (cfg_word),
        .res_valid  (res_valid),
        .res_data   (res_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fld(input int op, input int sa, input int sb, input int imm);
        return {4'(imm), 4'(sb), 4'(sa), 4'(op)};
    endfunction

    function automatic logic [31:0] pe_eval(input int op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            0:  return a;
            1:  return a + b;
            2:  return a - b;
            3:  return a & b;
            4:  return a | b;
            5:  return a ^ b;
            6:  return a << b[4:0];
            7:  return a >> b[4:0];
            8:  return 32'($signed(a) >>> b[4:0]);
            9:  return a * b;
            10: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            11: return (a < b) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [31:0] model(input logic [133:0] c, input logic [127:0] ov);
        logic [31:0] y [8];
        for (int p = 0; p < 8; p++) begin
            logic [15:0] f;
            logic [31:0] av, bv;
            int sa, sb;
            f  = c[p*16 +: 16];
            sa = int'(f[7:4]);
            sb = int'(f[11:8]);
            if (sa < 4) av = ov[sa*32 +: 32];
            else if (sa < 4 + p) av = y[sa-4];
            else av = {28'd0, f[15:12]};
            if (sb < 4) bv = ov[sb*32 +: 32];
            else if (sb < 4 + p) bv = y[sb-4];
            else bv = {28'd0, f[15:12]};
            y[p] = pe_eval(int'(f[3:0]), av, bv);
        end
        return y[c[130:128]];
    endfunction

    // Called at a negedge; returns at the next negedge
    task automatic cfg_write(input logic [3:0] idx, input logic [133:0] w);
        cfg_we = 1'b1; cfg_idx = idx; cfg_word = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic issue_chk(input string req, input logic [3:0] ctx,
                             input logic [127:0] ov, input logic [31:0] exp);
        issue_valid = 1'b1; issue_ctx = ctx; issue_opnds = ov;
        @(negedge clk);
        issue_valid = 1'b0;
        check(req, {31'd0, res_valid}, 32'd1);
        check(req, res_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [133:0] w;
        logic [127:0] ov;
        logic [31:0]  held;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        check("R1 valid", {31'd0, res_valid}, 32'd0);
        check("R1 data", res_data, 32'd0);

        // R1 R7: zeroed contexts return operand 0
        for (int c = 0; c < 16; c++) begin
            ov = {32'hCAFE0003, 32'hCAFE0002, 32'hCAFE0001, 32'h1000_0000 + 32'(c)};
            issue_chk("R1 default ctx", 4'(c), ov, 32'h1000_0000 + 32'(c));
        end

        // R3: opcode sweep on element 0
        for (int op = 0; op < 16; op++) begin
            w = '0;
            w[15:0] = fld(op, 0, 1, 0);
            cfg_write(4'd1, w);
            for (int k = 0; k < 6; k++) begin
                logic [31:0] a, b;
                case (k)
                    0: begin a = 32'h0000_0007; b = 32'h0000_0003; end
                    1: begin a = 32'hFFFF_FFF0; b = 32'h0000_0025; end
                    2: begin a = 32'h8000_0001; b = 32'h7FFF_FFFF; end
                    3: begin a = 32'h1234_5678; b = 32'h0000_0000; end
                    4: begin a = 32'hDEAD_BEEF; b = 32'hFFFF_FFFF; end
                    default: begin a = 32'h0001_0000; b = 32'h0001_0000; end
                endcase
                ov = {32'hA5A5_A5A5, 32'h5A5A_5A5A, b, a};
                issue_chk("R3 opcode", 4'd1, ov, pe_eval(op, a, b));
            end
        end

        // R5: output select, element p adds constant p+1 to operand 0
        for (int s = 0; s < 8; s++) begin
            w = '0;
            for (int p = 0; p < 8; p++) w[p*16 +: 16] = fld(1, 0, 15, p + 1);
            w[130:128] = 3'(s);
            cfg_write(4'd2, w);
            ov = {32'd3, 32'd2, 32'd1, 32'h0000_0100};
            issue_chk("R5 out select", 4'd2, ov, 32'h0000_0100 + 32'(s + 1));
        end

        // R6: reserved bits ignored
        w[133:131] = 3'b101;
        cfg_write(4'd2, w);
        issue_chk("R6 reserved bits", 4'd2, ov, 32'h0000_0108);

        // R9 R4: eight-element chain within one issue
        w = '0;
        w[15:0] = fld(1, 0, 1, 0);
        for (int p = 1; p < 8; p++) w[p*16 +: 16] = fld(1, 4 + p - 1, p % 4, 0);
        w[130:128] = 3'd7;
        cfg_write(4'd6, w);
        ov = {32'd40, 32'd30, 32'd20, 32'd10};
        check("R9 chain model", model(w, ov), 32'd220);
        issue_chk("R9 chain", 4'd6, ov, 32'd220);

        // R4: forward reference falls back to the constant
        w = '0;
        w[15:0] = fld(1, 9, 2, 9);
        cfg_write(4'd7, w);
        ov = {32'd0, 32'd500, 32'd0, 32'd0};
        issue_chk("R4 forward ref", 4'd7, ov, 32'd509);

        // R4: legal left neighbour, element 3 subtracts element 2 from operand 3
        w = '0;
        w[2*16 +: 16] = fld(5, 0, 1, 0);
        w[3*16 +: 16] = fld(2, 3, 6, 0);
        w[130:128] = 3'd3;
        cfg_write(4'd8, w);
        ov = {32'd1000, 32'd0, 32'h0F, 32'hF0};
        issue_chk("R4 neighbour", 4'd8, ov, 32'd1000 - 32'hFF);

        // R7: back-to-back issues alternating contexts
        w = '0; w[15:0] = fld(2, 0, 1, 0);
        cfg_write(4'd3, w);
        w = '0; w[15:0] = fld(5, 0, 1, 0);
        cfg_write(4'd4, w);
        ov = {32'd0, 32'd0, 32'h0000_00FF, 32'h0000_0F0F};
        issue_valid = 1'b1; issue_opnds = ov;
        issue_ctx = 4'd3;
        @(negedge clk);
        check("R7 b2b first", res_data, 32'h0000_0E10);
        issue_ctx = 4'd4;
        @(negedge clk);
        check("R7 b2b second", res_data, 32'h0000_0FF0);
        issue_ctx = 4'd3;
        @(negedge clk);
        check("R7 b2b third", res_data, 32'h0000_0E10);
        check("R7 valid", {31'd0, res_valid}, 32'd1);
        issue_valid = 1'b0;

        // R2: no issue keeps data and drops valid
        held = res_data;
        issue_opnds = '1;
        @(negedge clk);
        check("R2 valid drop", {31'd0, res_valid}, 32'd0);
        check("R2 data hold", res_data, held);

        // R8: write and issue to the same context in one cycle
        w = '0; w[15:0] = fld(1, 0, 1, 0);
        cfg_write(4'd5, w);
        w = '0; w[15:0] = fld(9, 0, 1, 0);
        ov = {32'd0, 32'd0, 32'd7, 32'd6};
        cfg_we = 1'b1; cfg_idx = 4'd5; cfg_word = w;
        issue_valid = 1'b1; issue_ctx = 4'd5; issue_opnds = ov;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R8 old ctx same cycle", res_data, 32'd13);
        @(negedge clk);
        issue_valid = 1'b0;
        check("R8 new ctx next cycle", res_data, 32'd42);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule